// File: doc/BRIEF.md
# SPI Control Port Frame Decoder

This block is the slave side of a byte-oriented serial control port. It samples an SPI-style link (serial clock, active-low select, data in, data out) in the system clock domain and assembles each frame. It then turns the frame into one decoded write, or into a read request whose 24-bit answer it shifts back out. Every frame opens with a two-byte header. That header holds five reserved zero bits, a read flag and a 10-bit register address. The address picks the payload layout that follows: a plain 24-bit data word, a safeload frame with a nested 8-bit parameter address and a 22-bit parameter, or a trap setup with a 9-bit program-counter value and a 2-bit capture-register select.

Decoded writes leave through a valid/ready stream (`wr_*`). A write stays on the outputs, unchanged, until the consumer accepts it with `wr_ready`. There is no queue behind it: a frame that completes while a write is still held is dropped. Read requests leave through a second valid/ready stream (`rd_req_*`) under the same hold rule. The answer comes back on `rd_rsp_valid`/`rd_rsp_data`, which is always accepted. A `busy` input from the boot sequencer suppresses writes while it is high.

Top module: `spi_cp_decoder`

## Requirements
- R1: Serial bits are taken on rising serial-clock edges while `cs_n` is low, MSB first. Header bits 15..11 are reserved, bit 10 is the read flag (1 = read) and bits 9..0 are the register address, which appears on `wr_addr` / `rd_req_addr`.
- R2: A header whose reserved bits are not all zero produces neither a write nor a read request for that frame.
- R3: At an address other than the two special ones, a write frame is 40 bits long. The frame has the header followed by a 24-bit word, sent most significant byte first. It yields `wr_kind` = 0 and `wr_data` = that word.
- R4: At the safeload address (default 0x200), a write frame is 48 bits long. The frame has the header, then an 8-bit parameter address, then three bytes whose top two bits are ignored. It yields `wr_kind` = 1, `wr_param` = the parameter address, `wr_data[21:0]` = the parameter and `wr_data[23:22]` = 0.
- R5: At the capture address (default 0x201), a write frame is 32 bits long. The frame has the header, a byte carrying trap bits 8..6 in its low three bits, and a byte carrying trap bits 5..0 then a 2-bit select. It yields `wr_kind` = 2, `wr_data[10:2]` = trap, `wr_data[1:0]` = select, all other data bits 0, and `wr_cap_sel` = one-hot of the select (bit n for select n). For kinds 0 and 1, `wr_cap_sel` and `wr_param` (kind 0) are 0.
- R6: If `cs_n` rises before the last bit of a write frame, the frame is discarded and no write is emitted.
- R7: Bits clocked in after a write frame is complete, before `cs_n` rises, are ignored.
- R8: A frame that completes while `busy` is high emits no write.
- R9: Once `wr_valid` is high, it and all `wr_*` fields hold steady until a cycle with `wr_ready` high. A frame that completes while `wr_valid` is high is dropped.
- R10: A read header raises `rd_req_valid` with the address. The request is held until `rd_req_ready`, and a read frame emits no write.
- R11: `rd_rsp_valid` during a frame loads the 24-bit answer. `miso` shows bit 23 at once and advances one bit per falling serial-clock edge. `miso` is 0 while `cs_n` is high and before an answer arrives.
- R12: After reset, `wr_valid`, `rd_req_valid`, `miso` and all write fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy | input | 1 | Boot in progress; blocks writes |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial read data out |
| wr_valid | output | 1 | Decoded write available |
| wr_ready | input | 1 | Consumer accepts the write |
| wr_kind | output | 2 | 0 data, 1 safeload, 2 capture setup |
| wr_addr | output | 10 | Register address from header |
| wr_param | output | 8 | Safeload parameter address |
| wr_data | output | 24 | Payload word, layout per kind |
| wr_cap_sel | output | 4 | One-hot capture register select |
| rd_req_valid | output | 1 | Read request pending |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 10 | Read address |
| rd_rsp_valid | input | 1 | Read answer strobe |
| rd_rsp_data | input | 24 | Read answer word |

## Verification
Frames of all three layouts are sent from a vector table. Data words with bits set at both ends of the byte order show whether the bytes are ordered and aligned correctly. A safeload parameter with its two ignored bits set shows whether they are masked. Trap values paired with different selects show the bit split between trap and select and the one-hot decode. Frames with a reserved bit set, frames cut short by `cs_n`, and frames followed by extra bits show where a frame starts and ends. Directed cases hold `busy` high, leave a write unaccepted while a second frame arrives, and run a full read with a patterned answer word. Each of these is decided by what appears at the ports.

// File: rtl/spi_cp_pkg.sv
package spi_cp_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 24;
  localparam int PADR_W = 8;
  localparam int HDR_W  = 16;
  localparam int PAY_W  = 32;
  localparam int CNT_W  = 6;
  localparam int SEL_N  = 4;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_SAFE = 2'd1,
    KIND_CAPT = 2'd2
  } frame_kind_e;

  // frame lengths in bits, header included
  localparam logic [CNT_W-1:0] LEN_DATA = CNT_W'(HDR_W + DATA_W);
  localparam logic [CNT_W-1:0] LEN_SAFE = CNT_W'(HDR_W + PADR_W + DATA_W);
  localparam logic [CNT_W-1:0] LEN_CAPT = CNT_W'(HDR_W + 16);
endpackage

// File: rtl/spi_cp_sync.sv
module spi_cp_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/spi_cp_rx.sv
module spi_cp_rx
  import spi_cp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_act,
  input  logic             sclk_rise,
  input  logic             mosi_s,
  input  logic [CNT_W-1:0] frame_len,   // 0 = no write completion
  output logic             hdr_stb,
  output logic [HDR_W-1:0] hdr,
  output logic             done_stb,
  output logic [PAY_W-1:0] payload
);
  logic [CNT_W-1:0] cnt_q;
  logic             hdr_seen_q;
  logic             closed_q;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      hdr_seen_q <= 1'b0;
      closed_q   <= 1'b0;
      hdr_stb    <= 1'b0;
      done_stb   <= 1'b0;
      hdr        <= '0;
      payload    <= '0;
    end else begin
      hdr_stb  <= 1'b0;
      done_stb <= 1'b0;
      if (!cs_act) begin
        cnt_q      <= '0;
        hdr_seen_q <= 1'b0;
        closed_q   <= 1'b0;
      end else if (sclk_rise && !closed_q) begin
        payload <= {payload[PAY_W-2:0], mosi_s};
        if (cnt_q != '1) cnt_q <= cnt_nx;
        if (cnt_q == CNT_W'(HDR_W - 1)) begin
          hdr        <= {payload[HDR_W-2:0], mosi_s};
          hdr_stb    <= 1'b1;
          hdr_seen_q <= 1'b1;
        end
        if (hdr_seen_q && frame_len != '0 && cnt_nx == frame_len) begin
          done_stb <= 1'b1;
          closed_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_cp_tx.sv
module spi_cp_tx
  import spi_cp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_fall,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              miso
);
  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !cs_act) sr_q <= '0;
    else if (load)         sr_q <= load_data;
    else if (sclk_fall)    sr_q <= {sr_q[DATA_W-2:0], 1'b0};
  end

  assign miso = sr_q[DATA_W-1];
endmodule

// File: rtl/spi_cp_decode.sv
module spi_cp_decode
  import spi_cp_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SAFE_ADDR = 10'h200,
  parameter logic [ADDR_W-1:0] CAPT_ADDR = 10'h201
) (
  input  logic [HDR_W-1:0]  hdr,
  input  logic [PAY_W-1:0]  payload,
  output logic              hdr_ok,
  output logic              is_read,
  output logic [ADDR_W-1:0] addr,
  output frame_kind_e       kind,
  output logic [CNT_W-1:0]  frame_len,
  output logic [DATA_W-1:0] f_data,
  output logic [PADR_W-1:0] f_param,
  output logic [SEL_N-1:0]  f_sel
);
  localparam int RSV_W = HDR_W - ADDR_W - 1;

  always_comb begin
    hdr_ok  = (hdr[HDR_W-1 -: RSV_W] == '0);
    is_read = hdr[ADDR_W];
    addr    = hdr[ADDR_W-1:0];
    if (addr == SAFE_ADDR)      kind = KIND_SAFE;
    else if (addr == CAPT_ADDR) kind = KIND_CAPT;
    else                        kind = KIND_DATA;
    if (!hdr_ok || is_read) frame_len = '0;
    else begin
      unique case (kind)
        KIND_SAFE: frame_len = LEN_SAFE;
        KIND_CAPT: frame_len = LEN_CAPT;
        default:   frame_len = LEN_DATA;
      endcase
    end
  end

  always_comb begin
    f_data  = '0;
    f_param = '0;
    f_sel   = '0;
    unique case (kind)
      KIND_SAFE: begin
        f_param      = payload[PAY_W-1 -: PADR_W];
        f_data[21:0] = payload[21:0];
      end
      KIND_CAPT: begin
        f_data[10:0] = payload[10:0];
        for (int i = 0; i < SEL_N; i++)
          f_sel[i] = (payload[1:0] == 2'(i));
      end
      default: f_data = payload[DATA_W-1:0];
    endcase
  end
endmodule

// File: rtl/spi_cp_decoder.sv
module spi_cp_decoder
  import spi_cp_pkg::*;
#(
  parameter logic [9:0] SAFE_ADDR   = 10'h200,
  parameter logic [9:0] CAPT_ADDR   = 10'h201,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busy,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [1:0]  wr_kind,
  output logic [9:0]  wr_addr,
  output logic [7:0]  wr_param,
  output logic [23:0] wr_data,
  output logic [3:0]  wr_cap_sel,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [9:0]  rd_req_addr,
  input  logic        rd_rsp_valid,
  input  logic [23:0] rd_rsp_data
);
  // ---- synchronise the serial pins ----
  logic [2:0] pins_s;
  logic       sclk_s, sclk_d, cs_n_s, mosi_s;
  logic       cs_act, sclk_rise, sclk_fall;

  spi_cp_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b010)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({sclk, cs_n, mosi}),
    .sync_out (pins_s)
  );
  assign {sclk_s, cs_n_s, mosi_s} = pins_s;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign cs_act    = !cs_n_s;
  assign sclk_rise = sclk_s && !sclk_d;
  assign sclk_fall = !sclk_s && sclk_d;

  // ---- frame assembly ----
  logic             hdr_stb, done_stb;
  logic [HDR_W-1:0] hdr;
  logic [PAY_W-1:0] payload;
  logic [CNT_W-1:0] frame_len;

  spi_cp_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .mosi_s    (mosi_s),
    .frame_len (frame_len),
    .hdr_stb   (hdr_stb),
    .hdr       (hdr),
    .done_stb  (done_stb),
    .payload   (payload)
  );

  // ---- decode ----
  logic              hdr_ok, is_read;
  logic [ADDR_W-1:0] dec_addr;
  frame_kind_e       dec_kind;
  logic [DATA_W-1:0] f_data;
  logic [PADR_W-1:0] f_param;
  logic [SEL_N-1:0]  f_sel;

  spi_cp_decode #(.SAFE_ADDR(SAFE_ADDR), .CAPT_ADDR(CAPT_ADDR)) u_dec (
    .hdr       (hdr),
    .payload   (payload),
    .hdr_ok    (hdr_ok),
    .is_read   (is_read),
    .addr      (dec_addr),
    .kind      (dec_kind),
    .frame_len (frame_len),
    .f_data    (f_data),
    .f_param   (f_param),
    .f_sel     (f_sel)
  );

  // ---- write stream register ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid   <= 1'b0;
      wr_kind    <= '0;
      wr_addr    <= '0;
      wr_param   <= '0;
      wr_data    <= '0;
      wr_cap_sel <= '0;
    end else if (wr_valid && wr_ready) begin
      wr_valid <= 1'b0;
    end else if (done_stb && !busy && !wr_valid) begin
      wr_valid   <= 1'b1;
      wr_kind    <= dec_kind;
      wr_addr    <= dec_addr;
      wr_param   <= f_param;
      wr_data    <= f_data;
      wr_cap_sel <= f_sel;
    end
  end

  // ---- read request stream ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_req_valid <= 1'b0;
      rd_req_addr  <= '0;
    end else if (rd_req_valid && rd_req_ready) begin
      rd_req_valid <= 1'b0;
    end else if (hdr_stb && hdr_ok && is_read && !rd_req_valid) begin
      rd_req_valid <= 1'b1;
      rd_req_addr  <= dec_addr;
    end
  end

  // ---- read-back shifter ----
  spi_cp_tx u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .sclk_fall (sclk_fall),
    .load      (rd_rsp_valid),
    .load_data (rd_rsp_data),
    .miso      (miso)
  );
endmodule

// File: rtl/spi_cp_decoder_chk.sv
module spi_cp_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        cs_n,
  input logic        miso,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [1:0]  wr_kind,
  input logic [9:0]  wr_addr,
  input logic [7:0]  wr_param,
  input logic [23:0] wr_data,
  input logic [3:0]  wr_cap_sel,
  input logic        rd_req_valid,
  input logic        rd_req_ready,
  input logic [9:0]  rd_req_addr
);
  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)
      && $stable(wr_kind) && $stable(wr_param) && $stable(wr_cap_sel));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  assert_busy_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> !$past(busy));

  assert_cap_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_kind == 2'd2 |-> $countones(wr_cap_sel) == 1);

  assert_cap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_kind != 2'd2 |-> wr_cap_sel == 4'd0);

  assert_miso_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) |-> !miso);
endmodule

bind spi_cp_decoder spi_cp_decoder_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .cs_n         (cs_n),
  .miso         (miso),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_kind      (wr_kind),
  .wr_addr      (wr_addr),
  .wr_param     (wr_param),
  .wr_data      (wr_data),
  .wr_cap_sel   (wr_cap_sel),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr)
);

// File: tb/spi_cp_decoder_tb.sv
module spi_cp_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busy = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [1:0]  wr_kind;
  logic [9:0]  wr_addr;
  logic [7:0]  wr_param;
  logic [23:0] wr_data;
  logic [3:0]  wr_cap_sel;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [9:0]  rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [23:0] rd_rsp_data = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;   // 250 MHz

  spi_cp_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_param(wr_param),
    .wr_data(wr_data), .wr_cap_sel(wr_cap_sel), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data)
  );

  typedef struct packed {
    logic [47:0] frame;
    logic [5:0]  len;
    logic        ev;
    logic [1:0]  kind;
    logic [9:0]  addr;
    logic [23:0] data;
    logic [7:0]  param;
    logic [3:0]  sel;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    // R3 plain data, bytes at both ends set
    '{48'h00_0123A5C3F0, 6'd40, 1'b1, 2'd0, 10'h123, 24'hA5C3F0, 8'h00, 4'b0000},
    // R3 top address, lone low bit
    '{48'h00_03FF000001, 6'd40, 1'b1, 2'd0, 10'h3FF, 24'h000001, 8'h00, 4'b0000},
    // R4 safeload, ignored top bits set
    '{48'h02005AFFFF0E,  6'd48, 1'b1, 2'd1, 10'h200, 24'h3FFF0E, 8'h5A, 4'b0000},
    // R5 capture trap 0x1A5 select 2
    '{48'h0000_02010696, 6'd32, 1'b1, 2'd2, 10'h201, 24'h000696, 8'h00, 4'b0100},
    // R5 capture trap 0 select 3
    '{48'h0000_02010003, 6'd32, 1'b1, 2'd2, 10'h201, 24'h000003, 8'h00, 4'b1000},
    // R2 reserved bit set
    '{48'h00_8123112233, 6'd40, 1'b0, 2'd0, 10'h000, 24'h000000, 8'h00, 4'b0000},
    // R6 truncated at 30 bits
    '{48'h0000_0055AABB, 6'd30, 1'b0, 2'd0, 10'h000, 24'h000000, 8'h00, 4'b0000},
    // R7 extra byte after complete data frame
    '{48'h0010123456FF,  6'd48, 1'b1, 2'd0, 10'h010, 24'h123456, 8'h00, 4'b0000}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] f, input int n, input bit keep_cs);
    cs_n = 1'b0;
    tick(4);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = f[i];
      tick(4);
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
      tick(4);
    end
    if (!keep_cs) begin
      cs_n = 1'b1;
      tick(8);
    end
  endtask

  task automatic accept();
    wr_ready = 1'b1;
    tick(1);
    wr_ready = 1'b0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(2);
    // R12 reset state
    check_eq("R12 reset outputs",
             {wr_valid, rd_req_valid, miso, wr_kind, wr_addr, wr_param, wr_data, wr_cap_sel},
             64'd0);

    // table walk (R1..R7)
    for (int v = 0; v < NV; v++) begin
      send(VECS[v].frame, int'(VECS[v].len), 1'b0);
      check_eq($sformatf("R1 vector %0d wr_valid", v), wr_valid, VECS[v].ev);
      if (VECS[v].ev) begin
        check_eq($sformatf("R3 R4 R5 vector %0d fields", v),
                 {wr_kind, wr_addr, wr_data, wr_param, wr_cap_sel},
                 {VECS[v].kind, VECS[v].addr, VECS[v].data, VECS[v].param, VECS[v].sel});
        accept();
      end
    end
    check_eq("R2 no read request from ignored frames", rd_req_valid, 1'b0);

    // R8 busy blocks writes
    busy = 1'b1;
    send(48'h00_0077ABCDEF, 40, 1'b0);
    check_eq("R8 busy drops write", wr_valid, 1'b0);
    busy = 1'b0;
    send(48'h00_0077ABCDEF, 40, 1'b0);
    check_eq("R8 write after busy", {wr_valid, wr_addr, wr_data}, {1'b1, 10'h077, 24'hABCDEF});
    accept();

    // R9 back-pressure: held write, second frame dropped
    send(48'h00_0011111111, 40, 1'b0);
    tick(20);
    send(48'h00_0022222222, 40, 1'b0);
    check_eq("R9 held write unchanged", {wr_valid, wr_addr, wr_data}, {1'b1, 10'h011, 24'h111111});
    accept();
    check_eq("R9 valid drops after accept", wr_valid, 1'b0);
    tick(4);
    check_eq("R9 second frame was dropped", wr_valid, 1'b0);

    // R10 / R11 read
    send(48'h0445, 16, 1'b1);
    check_eq("R10 read request", {rd_req_valid, rd_req_addr}, {1'b1, 10'h045});
    tick(3);
    check_eq("R10 request held", {rd_req_valid, rd_req_addr}, {1'b1, 10'h045});
    check_eq("R11 miso zero before answer", miso, 1'b0);
    rd_req_ready = 1'b1;
    tick(1);
    rd_req_ready = 1'b0;
    check_eq("R10 request cleared", rd_req_valid, 1'b0);
    rd_rsp_data  = 24'hC3A501;
    rd_rsp_valid = 1'b1;
    tick(1);
    rd_rsp_valid = 1'b0;
    tick(2);
    begin
      logic [23:0] got = '0;
      for (int i = 23; i >= 0; i--) begin
        got[i] = miso;
        sclk = 1'b1;
        tick(4);
        sclk = 1'b0;
        tick(6);
      end
      check_eq("R11 read word on miso", got, 24'hC3A501);
    end
    cs_n = 1'b1;
    tick(8);
    check_eq("R11 miso idle after frame", miso, 1'b0);
    check_eq("R10 read emits no write", wr_valid, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule